// File: doc/BRIEF.md
# Chained Vector Register Unit

This block executes element-wise integer vector instructions against a bank of vector registers. One instruction names a destination register and two source registers, an operation and a vector length. It is decoded once at issue. Its lane then reads one element pair per cycle, passes each result through a fixed-latency pipeline and writes it back to the destination register.

Two lanes can run at the same time. A second instruction that reads the destination of an instruction still in flight does not wait for the whole vector. It is issued as soon as the producer's first result leaves the pipeline. From then on it takes each element from the producer's write-back bus in the same cycle that element is written. Issue stalls while the destination register is still being written, while a needed source has not yet produced its first element, or while both lanes are busy.

A separate element write port loads vectors from the memory side. A combinational element read port exposes any register element. A per-register done mask reports completion.

Top module: `vchain_unit`

## Requirements
- R1: After reset no lane is busy, `done_mask` is all zero, and `ready` is high for any instruction with `start` low or high.
- R2: The operation code selects the result for each element index i below the vector length. Code 0 gives va[i]+vb[i], code 1 gives va[i]-vb[i], code 2 gives va[i]&vb[i] and code 3 gives va[i]|vb[i]. Add and subtract wrap modulo 2^64, and the result is written to vd[i].
- R3: Elements of the destination at indices at or above the vector length keep their previous values.
- R4: A `len` of 1 to 64 is used as given. A `len` of 0, or any value above 64, means a length of 64.
- R5: An instruction of length n is accepted on the clock edge where `start` and `ready` are both high. If the cycle count reads P after that edge, `done_mask[vd]` is high for exactly one cycle, when the count reads P+n+3. That is one cycle after the final element is written.
- R6: A lane writes its results on consecutive cycles with the element index rising by one each cycle.
- R7: An instruction whose source is the destination of an in-flight instruction is accepted exactly 3 edges after the producer, if the rest of issue is free. It produces the same values as running the two in sequence, and with equal lengths it completes 3 cycles after the producer.
- R8: Such a dependent instruction sees `ready` low for the 2 cycles before its source's first result is available.
- R9: An instruction whose destination is still being written stalls. With a producer of length n accepted at count P, it is accepted at count P+n+4, and the later writes overwrite only their own indices.
- R10: An independent instruction is accepted on the cycle after another while one lane is free. A third one stalls until a lane's final write is done, and at most one lane is started per edge.
- R11: No element of a source is read before its in-flight producer has written it or is writing it in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction request, held until accepted |
| op | input | 2 | Operation code (0 add, 1 subtract, 2 and, 3 or) |
| vd | input | 3 | Destination register |
| va | input | 3 | First source register |
| vb | input | 3 | Second source register |
| len | input | 7 | Vector length (0 or above 64 means 64) |
| ready | output | 1 | Request would be accepted at this edge |
| done_mask | output | 8 | One-cycle completion flag per destination register |
| fill_en | input | 1 | Element load strobe |
| fill_reg | input | 3 | Register for the element load |
| fill_idx | input | 6 | Element index for the element load |
| fill_data | input | 64 | Element load data |
| obs_reg | input | 3 | Register for the element read |
| obs_idx | input | 6 | Element index for the element read |
| obs_data | output | 64 | Element read data, combinational |

## Verification
The hardest situation to reach is the exact chain slot. Here a dependent instruction's reads land in the same cycle as the producer's write-backs, so every operand must come from the bypass and not from the register array. The stimulus raises the dependent request on the cycle right after the producer is accepted and holds it. The stall count and the acceptance edge are then measured, and the full 64-element result is compared. The write-after-write and both-lanes-busy stalls are reached the same way, by back-to-back requests whose acceptance edges are counted against the producer's.

// File: rtl/vcu_pkg.sv
package vcu_pkg;

    localparam int VCU_NREG = 8;
    localparam int VCU_VLEN = 64;
    localparam int VCU_DW   = 64;
    localparam int VCU_RW   = $clog2(VCU_NREG);
    localparam int VCU_IW   = $clog2(VCU_VLEN);
    localparam int VCU_LW   = $clog2(VCU_VLEN + 1);

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_OR  = 2'd3
    } vop_e;

    typedef struct packed {
        vop_e              op;
        logic [VCU_RW-1:0] vd;
        logic [VCU_RW-1:0] va;
        logic [VCU_RW-1:0] vb;
        logic [VCU_LW-1:0] len;
    } vinstr_t;

    typedef struct packed {
        logic              vld;
        logic              last;
        logic [VCU_RW-1:0] vreg;
        logic [VCU_IW-1:0] idx;
        logic [VCU_DW-1:0] data;
    } velem_t;

    function automatic logic [VCU_DW-1:0] vop_eval(vop_e o, logic [VCU_DW-1:0] a,
                                                   logic [VCU_DW-1:0] b);
        case (o)
            OP_ADD:  return a + b;
            OP_SUB:  return a - b;
            OP_AND:  return a & b;
            default: return a | b;
        endcase
    endfunction

    function automatic logic [VCU_LW-1:0] eff_len(logic [VCU_LW-1:0] raw);
        if (raw == '0 || raw > VCU_LW'(VCU_VLEN))
            return VCU_LW'(VCU_VLEN);
        return raw;
    endfunction

endpackage

// File: rtl/vcu_regfile.sv
module vcu_regfile
    import vcu_pkg::*;
#(
    parameter int NWR = 3,
    parameter int NRD = 5
) (
    input  logic                          clk,
    input  logic [NWR-1:0]                wr_en,
    input  logic [NWR-1:0][VCU_RW-1:0]    wr_reg,
    input  logic [NWR-1:0][VCU_IW-1:0]    wr_idx,
    input  logic [NWR-1:0][VCU_DW-1:0]    wr_data,
    input  logic [NRD-1:0][VCU_RW-1:0]    rd_reg,
    input  logic [NRD-1:0][VCU_IW-1:0]    rd_idx,
    output logic [NRD-1:0][VCU_DW-1:0]    rd_data
);

    logic [VCU_DW-1:0] mem [VCU_NREG][VCU_VLEN];

    // Later ports win; port 0 is the load path, lanes follow.
    always_ff @(posedge clk) begin
        for (int w = 0; w < NWR; w++) begin
            if (wr_en[w])
                mem[wr_reg[w]][wr_idx[w]] <= wr_data[w];
        end
    end

    always_comb begin
        for (int r = 0; r < NRD; r++)
            rd_data[r] = mem[rd_reg[r]][rd_idx[r]];
    end

endmodule

// File: rtl/vcu_issue.sv
module vcu_issue
    import vcu_pkg::*;
#(
    parameter int NLANE = 2
) (
    input  logic                          start,
    input  logic [VCU_RW-1:0]             req_vd,
    input  logic [VCU_RW-1:0]             req_va,
    input  logic [VCU_RW-1:0]             req_vb,
    input  logic [NLANE-1:0]              busy,
    input  logic [NLANE-1:0]              age_ok,
    input  logic [NLANE-1:0][VCU_RW-1:0]  dst,
    output logic                          ready,
    output logic [NLANE-1:0]              go
);

    logic             dst_hit;
    logic             src_wait;
    logic             found;
    logic [NLANE-1:0] pick;

    always_comb begin
        dst_hit  = 1'b0;
        src_wait = 1'b0;
        found    = 1'b0;
        pick     = '0;
        for (int u = 0; u < NLANE; u++) begin
            if (busy[u] && dst[u] == req_vd)
                dst_hit = 1'b1;
            if (busy[u] && !age_ok[u] && (dst[u] == req_va || dst[u] == req_vb))
                src_wait = 1'b1;
            if (!busy[u] && !found) begin
                found   = 1'b1;
                pick[u] = 1'b1;
            end
        end
        ready = found && !dst_hit && !src_wait;
        go    = (start && ready) ? pick : '0;
    end

endmodule

// File: rtl/vcu_lane.sv
module vcu_lane
    import vcu_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  vinstr_t           ins_in,
    output logic              busy,
    output logic              age_ok,
    output logic [VCU_RW-1:0] dst,
    output logic [VCU_LW-1:0] len_o,
    output logic              rd_act,
    output logic [VCU_RW-1:0] ra,
    output logic [VCU_RW-1:0] rb,
    output logic [VCU_IW-1:0] ridx,
    input  logic [VCU_DW-1:0] opa,
    input  logic [VCU_DW-1:0] opb,
    output velem_t            wb
);

    localparam int AGW = $clog2(LAT + 1);

    vinstr_t           ins;
    logic [VCU_LW-1:0] rd_cnt;
    logic [AGW-1:0]    age;
    velem_t            stg [LAT];
    velem_t            head;

    assign rd_act = busy && (rd_cnt < ins.len);
    assign ra     = ins.va;
    assign rb     = ins.vb;
    assign ridx   = rd_cnt[VCU_IW-1:0];
    assign dst    = ins.vd;
    assign len_o  = ins.len;
    assign age_ok = (age >= AGW'(LAT));
    assign wb     = stg[LAT-1];

    always_comb begin
        head.vld  = rd_act;
        head.last = (rd_cnt == ins.len - VCU_LW'(1));
        head.vreg = ins.vd;
        head.idx  = rd_cnt[VCU_IW-1:0];
        head.data = vop_eval(ins.op, opa, opb);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            ins    <= '0;
            rd_cnt <= '0;
            age    <= '0;
        end else if (go) begin
            busy   <= 1'b1;
            ins    <= ins_in;
            rd_cnt <= '0;
            age    <= AGW'(1);
        end else begin
            if (rd_act)
                rd_cnt <= rd_cnt + VCU_LW'(1);
            if (busy && !age_ok)
                age <= age + AGW'(1);
            if (wb.vld && wb.last)
                busy <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LAT; k++)
                stg[k] <= '0;
        end else begin
            stg[0] <= head;
            for (int k = 1; k < LAT; k++)
                stg[k] <= stg[k-1];
        end
    end

endmodule

// File: rtl/vchain_unit.sv
module vchain_unit
    import vcu_pkg::*;
#(
    parameter int NLANE = 2,
    parameter int LAT   = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [1:0]          op,
    input  logic [VCU_RW-1:0]   vd,
    input  logic [VCU_RW-1:0]   va,
    input  logic [VCU_RW-1:0]   vb,
    input  logic [VCU_LW-1:0]   len,
    output logic                ready,
    output logic [VCU_NREG-1:0] done_mask,
    input  logic                fill_en,
    input  logic [VCU_RW-1:0]   fill_reg,
    input  logic [VCU_IW-1:0]   fill_idx,
    input  logic [VCU_DW-1:0]   fill_data,
    input  logic [VCU_RW-1:0]   obs_reg,
    input  logic [VCU_IW-1:0]   obs_idx,
    output logic [VCU_DW-1:0]   obs_data
);

    localparam int NWR = NLANE + 1;
    localparam int NRD = 2 * NLANE + 1;

    vinstr_t                     req;
    logic [NLANE-1:0]            go_v, busy_v, ageok_v, ract_v, wbvld_v, wblast_v;
    logic [NLANE-1:0][VCU_RW-1:0] dst_v, ra_v, rb_v, wbreg_v;
    logic [NLANE-1:0][VCU_IW-1:0] ridx_v, wbidx_v;
    logic [NLANE-1:0][VCU_LW-1:0] len_v;
    logic [NLANE-1:0][VCU_DW-1:0] opa_v, opb_v;
    velem_t                      wb_v [NLANE];

    logic [NWR-1:0]              wr_en;
    logic [NWR-1:0][VCU_RW-1:0]  wr_reg;
    logic [NWR-1:0][VCU_IW-1:0]  wr_idx;
    logic [NWR-1:0][VCU_DW-1:0]  wr_data;
    logic [NRD-1:0][VCU_RW-1:0]  rd_reg;
    logic [NRD-1:0][VCU_IW-1:0]  rd_idx;
    logic [NRD-1:0][VCU_DW-1:0]  rd_data;
    logic [VCU_NREG-1:0]         done_nx;

    always_comb begin
        req.op  = vop_e'(op);
        req.vd  = vd;
        req.va  = va;
        req.vb  = vb;
        req.len = eff_len(len);
    end

    vcu_issue #(.NLANE(NLANE)) u_issue (
        .start  (start),
        .req_vd (vd),
        .req_va (va),
        .req_vb (vb),
        .busy   (busy_v),
        .age_ok (ageok_v),
        .dst    (dst_v),
        .ready  (ready),
        .go     (go_v)
    );

    for (genvar u = 0; u < NLANE; u++) begin : g_lane
        vcu_lane #(.LAT(LAT)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .go     (go_v[u]),
            .ins_in (req),
            .busy   (busy_v[u]),
            .age_ok (ageok_v[u]),
            .dst    (dst_v[u]),
            .len_o  (len_v[u]),
            .rd_act (ract_v[u]),
            .ra     (ra_v[u]),
            .rb     (rb_v[u]),
            .ridx   (ridx_v[u]),
            .opa    (opa_v[u]),
            .opb    (opb_v[u]),
            .wb     (wb_v[u])
        );

        assign wbvld_v[u]  = wb_v[u].vld;
        assign wblast_v[u] = wb_v[u].last;
        assign wbreg_v[u]  = wb_v[u].vreg;
        assign wbidx_v[u]  = wb_v[u].idx;

        assign rd_reg[2*u]   = ra_v[u];
        assign rd_idx[2*u]   = ridx_v[u];
        assign rd_reg[2*u+1] = rb_v[u];
        assign rd_idx[2*u+1] = ridx_v[u];

        assign wr_en[u+1]   = wb_v[u].vld;
        assign wr_reg[u+1]  = wb_v[u].vreg;
        assign wr_idx[u+1]  = wb_v[u].idx;
        assign wr_data[u+1] = wb_v[u].data;

        // Chaining bypass: an element on any write-back bus this cycle
        // replaces the stale array copy.
        always_comb begin
            opa_v[u] = rd_data[2*u];
            opb_v[u] = rd_data[2*u+1];
            for (int w = 0; w < NLANE; w++) begin
                if (wb_v[w].vld && wb_v[w].idx == ridx_v[u]) begin
                    if (wb_v[w].vreg == ra_v[u])
                        opa_v[u] = wb_v[w].data;
                    if (wb_v[w].vreg == rb_v[u])
                        opb_v[u] = wb_v[w].data;
                end
            end
        end
    end

    assign wr_en[0]   = fill_en;
    assign wr_reg[0]  = fill_reg;
    assign wr_idx[0]  = fill_idx;
    assign wr_data[0] = fill_data;

    assign rd_reg[NRD-1] = obs_reg;
    assign rd_idx[NRD-1] = obs_idx;
    assign obs_data      = rd_data[NRD-1];

    vcu_regfile #(.NWR(NWR), .NRD(NRD)) u_rf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_reg  (wr_reg),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_reg  (rd_reg),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    always_comb begin
        done_nx = '0;
        for (int w = 0; w < NLANE; w++)
            if (wb_v[w].vld && wb_v[w].last)
                done_nx[wb_v[w].vreg] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            done_mask <= '0;
        else
            done_mask <= done_nx;
    end

endmodule

// File: rtl/vcu_chk.sv
module vcu_chk
    import vcu_pkg::*;
#(
    parameter int NLANE = 2
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          ready,
    input logic [VCU_RW-1:0]             req_vd,
    input logic [VCU_RW-1:0]             req_va,
    input logic [VCU_RW-1:0]             req_vb,
    input logic [NLANE-1:0]              go,
    input logic [NLANE-1:0]              busy,
    input logic [NLANE-1:0][VCU_RW-1:0]  dst,
    input logic [NLANE-1:0][VCU_LW-1:0]  len,
    input logic [NLANE-1:0]              rd_act,
    input logic [NLANE-1:0][VCU_RW-1:0]  ra,
    input logic [NLANE-1:0][VCU_RW-1:0]  rb,
    input logic [NLANE-1:0][VCU_IW-1:0]  ridx,
    input logic [NLANE-1:0]              wb_vld,
    input logic [NLANE-1:0]              wb_last,
    input logic [NLANE-1:0][VCU_IW-1:0]  wb_idx,
    input logic [VCU_NREG-1:0]           done_mask
);

    AST_ONE_START: assert property (@(posedge clk) disable iff (rst) $onehot0(go)); // R10

    AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
        (busy == '0) |-> ready); // R1

    for (genvar r = 0; r < VCU_NREG; r++) begin : g_done
        AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
            done_mask[r] |=> !done_mask[r]); // R5
    end

    for (genvar u = 0; u < NLANE; u++) begin : g_u
        AST_STREAM_STEP: assert property (@(posedge clk) disable iff (rst)
            (wb_vld[u] && !wb_last[u]) |=>
            (wb_vld[u] && wb_idx[u] == $past(wb_idx[u]) + VCU_IW'(1))); // R6

        for (genvar w = 0; w < NLANE; w++) begin : g_w
            if (w != u) begin : g_pair
                // Producer link recorded when lane u starts.
                logic link_a, link_b;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        link_a <= 1'b0;
                        link_b <= 1'b0;
                    end else if (go[u]) begin
                        link_a <= busy[w] && dst[w] == req_va;
                        link_b <= busy[w] && dst[w] == req_vb;
                    end else if (wb_vld[w] && wb_last[w]) begin
                        link_a <= 1'b0;
                        link_b <= 1'b0;
                    end
                end

                AST_NO_WAW: assert property (@(posedge clk) disable iff (rst)
                    (go[u] && busy[w]) |-> dst[w] != req_vd); // R9

                AST_NO_EARLY_A: assert property (@(posedge clk) disable iff (rst)
                    (rd_act[u] && link_a && busy[w] && VCU_LW'(ridx[u]) < len[w]) |->
                    (wb_vld[w] && wb_idx[w] >= ridx[u])); // R11

                AST_NO_EARLY_B: assert property (@(posedge clk) disable iff (rst)
                    (rd_act[u] && link_b && busy[w] && VCU_LW'(ridx[u]) < len[w]) |->
                    (wb_vld[w] && wb_idx[w] >= ridx[u])); // R11
            end
        end
    end

    // Sources are not referenced by every lane pairing when NLANE is 1.
    logic unused_rb;
    assign unused_rb = ^rb;

endmodule

bind vchain_unit vcu_chk #(.NLANE(NLANE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ready     (ready),
    .req_vd    (vd),
    .req_va    (va),
    .req_vb    (vb),
    .go        (go_v),
    .busy      (busy_v),
    .dst       (dst_v),
    .len       (len_v),
    .rd_act    (ract_v),
    .ra        (ra_v),
    .rb        (rb_v),
    .ridx      (ridx_v),
    .wb_vld    (wbvld_v),
    .wb_last   (wblast_v),
    .wb_idx    (wbidx_v),
    .done_mask (done_mask)
);

// File: tb/sim_vchain_unit.sv
`timescale 1ns/1ps
module sim_vchain_unit;
    import vcu_pkg::*;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic [2:0]  vd = '0, va = '0, vb = '0;
    logic [6:0]  len = '0;
    logic        ready;
    logic [7:0]  done_mask;
    logic        fill_en = 1'b0;
    logic [2:0]  fill_reg = '0;
    logic [5:0]  fill_idx = '0;
    logic [63:0] fill_data = '0;
    logic [2:0]  obs_reg = '0;
    logic [5:0]  obs_idx = '0;
    logic [63:0] obs_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [63:0] m [8][64];

    vchain_unit #(.NLANE(2), .LAT(LAT)) u0 (
        .clk(clk), .rst(rst), .start(start), .op(op), .vd(vd), .va(va), .vb(vb),
        .len(len), .ready(ready), .done_mask(done_mask), .fill_en(fill_en),
        .fill_reg(fill_reg), .fill_idx(fill_idx), .fill_data(fill_data),
        .obs_reg(obs_reg), .obs_idx(obs_idx), .obs_data(obs_data)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    // {op[2], vd[3], va[3], vb[3], len[7]}
    localparam int NT = 8;
    localparam logic [17:0] TBL [NT] = '{
        {2'd0, 3'd2, 3'd0, 3'd1, 7'd64},
        {2'd1, 3'd3, 3'd1, 3'd0, 7'd10},
        {2'd2, 3'd4, 3'd2, 3'd3, 7'd1},
        {2'd3, 3'd5, 3'd4, 3'd0, 7'd0},
        {2'd0, 3'd6, 3'd6, 3'd6, 7'd100},
        {2'd1, 3'd7, 3'd5, 3'd2, 7'd63},
        {2'd2, 3'd0, 3'd7, 3'd1, 7'd33},
        {2'd3, 3'd1, 3'd0, 3'd0, 7'd2}
    };

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (R5): run hung, actual cycle %0d expected completion", cyc);
        summary();
        $finish;
    end

    task automatic check(input bit ok, input string req, input longint act,
                         input longint exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int elen(input logic [6:0] l);
        return (l == 0 || l > 64) ? 64 : int'(l);
    endfunction

    function automatic logic [63:0] calc(input logic [1:0] o, input logic [63:0] a,
                                         input logic [63:0] b);
        case (o)
            2'd0: return a + b;
            2'd1: return a - b;
            2'd2: return a & b;
            default: return a | b;
        endcase
    endfunction

    task automatic model(input logic [17:0] ins);
        for (int i = 0; i < elen(ins[6:0]); i++)
            m[ins[15:13]][i] = calc(ins[17:16], m[ins[12:10]][i], m[ins[9:7]][i]);
    endtask

    task automatic issue(input logic [17:0] ins, output int acc, output int stalls);
        stalls = 0;
        op = ins[17:16]; vd = ins[15:13]; va = ins[12:10]; vb = ins[9:7]; len = ins[6:0];
        start = 1'b1;
        #1;
        while (!ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        acc = cyc;
        start = 1'b0;
    endtask

    task automatic wait_done(input logic [2:0] r, output int t);
        while (!done_mask[r]) @(negedge clk);
        t = cyc;
    endtask

    task automatic check_reg(input logic [2:0] r, input string req);
        int bad = 0;
        logic [63:0] a0 = '0, e0 = '0;
        for (int i = 0; i < 64; i++) begin
            obs_reg = r; obs_idx = 6'(i);
            #1;
            if (obs_data !== m[r][i]) begin
                if (bad == 0) begin a0 = obs_data; e0 = m[r][i]; end
                bad++;
            end
        end
        check(bad == 0, req, a0, e0, $sformatf("register %0d first mismatching element", r));
    endtask

    initial begin
        int acc_a, acc_b, acc_c, st, dn_a, dn_b, dn_c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(done_mask == 0, "R1", done_mask, 0, "done mask after reset");
        start = 1'b1; vd = 3'd5; va = 3'd5; vb = 3'd2; #1;
        check(ready == 1'b1, "R1", ready, 1, "ready after reset");
        start = 1'b0;

        for (int r = 0; r < 8; r++) begin
            for (int i = 0; i < 64; i++) begin
                m[r][i] = (64'h9E37_79B9_7F4A_7C15 * 64'(r * 64 + i + 1)) ^ (64'(i) << 40);
                fill_en = 1'b1; fill_reg = 3'(r); fill_idx = 6'(i); fill_data = m[r][i];
                @(negedge clk);
            end
        end
        fill_en = 1'b0;

        // Table: R2 operations, R3 tail preserved, R4 length encoding, R5 timing
        for (int t = 0; t < NT; t++) begin
            issue(TBL[t], acc_a, st);
            wait_done(TBL[t][15:13], dn_a);
            check(dn_a - acc_a == elen(TBL[t][6:0]) + LAT, "R5", dn_a - acc_a,
                  elen(TBL[t][6:0]) + LAT, "done delay");
            @(negedge clk);
            check(done_mask == 0, "R5", done_mask, 0, "done lasts one cycle");
            model(TBL[t]);
            check_reg(TBL[t][15:13], (t == 2) ? "R3" : (t == 3 || t == 4) ? "R4" : "R2");
        end

        // R7/R8: chained consumer reads producer via bypass
        issue({2'd0, 3'd2, 3'd0, 3'd1, 7'd64}, acc_a, st);
        issue({2'd3, 3'd3, 3'd2, 3'd4, 7'd64}, acc_b, st);
        check(acc_b - acc_a == LAT, "R7", acc_b - acc_a, LAT, "chain accept edge");
        check(st == LAT - 1, "R8", st, LAT - 1, "chain stall cycles");
        wait_done(3'd2, dn_a);
        wait_done(3'd3, dn_b);
        check(dn_b - dn_a == LAT, "R7", dn_b - dn_a, LAT, "chain completion gap");
        model({2'd0, 3'd2, 3'd0, 3'd1, 7'd64});
        model({2'd3, 3'd3, 3'd2, 3'd4, 7'd64});
        repeat (2) @(negedge clk);
        check_reg(3'd2, "R7");
        check_reg(3'd3, "R7");

        // R9: write-after-write stall
        issue({2'd0, 3'd4, 3'd0, 3'd1, 7'd8}, acc_a, st);
        issue({2'd1, 3'd4, 3'd2, 3'd3, 7'd4}, acc_b, st);
        check(acc_b - acc_a == 8 + LAT + 1, "R9", acc_b - acc_a, 8 + LAT + 1, "WAW accept edge");
        wait_done(3'd4, dn_b);
        model({2'd0, 3'd4, 3'd0, 3'd1, 7'd8});
        model({2'd1, 3'd4, 3'd2, 3'd3, 7'd4});
        @(negedge clk);
        check_reg(3'd4, "R9");

        // R10: two lanes, third instruction waits for a free lane
        issue({2'd0, 3'd5, 3'd0, 3'd1, 7'd64}, acc_a, st);
        issue({2'd1, 3'd6, 3'd2, 3'd3, 7'd64}, acc_b, st);
        issue({2'd2, 3'd7, 3'd0, 3'd3, 7'd64}, acc_c, st);
        check(acc_b - acc_a == 1, "R10", acc_b - acc_a, 1, "second lane accept");
        check(acc_c - acc_a == 64 + LAT + 1, "R10", acc_c - acc_a, 64 + LAT + 1,
              "third waits for lane");
        wait_done(3'd7, dn_c);
        model({2'd0, 3'd5, 3'd0, 3'd1, 7'd64});
        model({2'd1, 3'd6, 3'd2, 3'd3, 7'd64});
        model({2'd2, 3'd7, 3'd0, 3'd3, 7'd64});
        @(negedge clk);
        check_reg(3'd5, "R10");
        check_reg(3'd6, "R10");
        check_reg(3'd7, "R10");

        // R11: chain where both sources come from the producer
        issue({2'd1, 3'd1, 3'd7, 3'd6, 7'd20}, acc_a, st);
        issue({2'd0, 3'd0, 3'd1, 3'd1, 7'd30}, acc_b, st);
        wait_done(3'd0, dn_b);
        model({2'd1, 3'd1, 3'd7, 3'd6, 7'd20});
        model({2'd0, 3'd0, 3'd1, 3'd1, 7'd30});
        @(negedge clk);
        check_reg(3'd0, "R11");
        check_reg(3'd1, "R11");

        summary();
        $finish;
    end

endmodule